// File: doc/BRIEF.md
# Receive label and decode filter

This block sits behind a serial receive decoder and in front of a receive word FIFO. Each completed 32-bit word arrives on a valid/ready input stream. The block then applies two optional checks. The label check compares the word's label byte against a table of programmable labels. The decode check compares two source/destination bits against a programmed pair. If either enabled check fails, the word is dropped. Words that pass go out on a valid/ready output stream. In the outgoing word, the top bit is replaced by a receive parity flag.

Bit i of a word carries serial bit i+1. The label is bits [7:0], the decode pair is bits [9:8], and bit 31 is the received parity bit.

The host fills the label table with a sequential access mode. Raising the label-mode control starts a sequence of host writes, which load locations 0 upward. Host reads in the same mode return the stored labels in the same order. Writes and reads share one pointer. Word reception is held off for the whole time label mode is high.

Back-pressure rules:
- The output holds one registered word.
- `in_ready` is high only when label mode is low and the output register is empty or being drained in the same cycle.
- A word that is offered while `in_ready` is low is not taken.
- `out_valid` and `out_data` stay unchanged while `out_ready` is low.

Top module: `arinc_rx_filter`

## Requirements
- R1: After reset, `out_valid` is 0, `host_rdata` is 0 and `in_ready` is 1.
- R2: With both checks disabled, every accepted word appears on the output on the cycle after acceptance, with `out_data[30:0]` equal to the input's bits [30:0].
- R3: `out_data[31]` is 0 when the accepted 32-bit word has an odd number of ones, and 1 when the count is even.
- R4: With `lbl_en` = 1, a word is forwarded only if `in_data[7:0]` equals one of the 16 stored labels. Otherwise `out_valid` stays 0.
- R5: A stored label of 8'h00 matches a word with label 8'h00, exactly like any other value.
- R6: With `sdi_en` = 1, a word is forwarded only if `in_data[9:8]` equals `sdi_code`.
- R7: With both checks enabled, a word is forwarded only if both checks pass.
- R8: After `label_mode` goes from 0 to 1, successive `host_wr` pulses store `host_wdata` into label locations 0, 1, …, 15, in that order.
- R9: While `label_mode` is 1, each `host_rd` pulse returns the next stored label on `host_rdata`, starting at location 0, valid from the cycle after the pulse.
- R10: While `label_mode` is 1, `in_ready` is 0 and no word is accepted.
- R11: Driving `label_mode` to 0 resets the shared pointer, so the next label sequence starts again at location 0.
- R12: Once 16 accesses have been made in one label-mode session, further writes leave the table unchanged and further reads leave `host_rdata` unchanged.
- R13: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds and `in_ready` is 0. When the word drains, a waiting input word is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Completed received word offered |
| in_data | input | 32 | Received word, bit i = serial bit i+1 |
| in_ready | output | 1 | Block accepts the offered word |
| out_valid | output | 1 | Filtered word available for the FIFO |
| out_data | output | 32 | Filtered word, bit 31 = parity-error flag |
| out_ready | input | 1 | FIFO takes the word |
| lbl_en | input | 1 | Enable label check |
| sdi_en | input | 1 | Enable decode-bit check |
| sdi_code | input | 2 | Required value of word bits [9:8] |
| label_mode | input | 1 | Sequential label-table access mode |
| host_wr | input | 1 | Label write pulse (label mode) |
| host_wdata | input | 8 | Label value to write |
| host_rd | input | 1 | Label read pulse (label mode) |
| host_rdata | output | 8 | Label read result |

## Verification
The bench builds the block with its default parameters: 16 labels of 8 bits. At these values a full session loads and reads back every location. The table holds both extreme values 8'h00 and 8'hFF, and the access pointer can be driven past its last location to show that overrun accesses are ignored. The patterns used are label hits and misses, every combination of the two checks, even and odd parity, and a stalled output.

// File: rtl/arinc_flt_pkg.sv
package arinc_flt_pkg;
  localparam int WORD_W  = 32;
  localparam int SDI_LSB = 8;
  localparam int SDI_W   = 2;

  typedef struct packed {
    logic             lbl_en;
    logic             sdi_en;
    logic [SDI_W-1:0] sdi_code;
  } filt_cfg_t;
endpackage

// File: rtl/lbl_store.sv
module lbl_store #(
  parameter int NUM = 16,
  parameter int W   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode,
  input  logic           wr,
  input  logic [W-1:0]   wdata,
  input  logic           rd,
  output logic [W-1:0]   rdata,
  output logic [NUM*W-1:0] table_flat
);
  localparam int IW = $clog2(NUM);
  localparam int PW = IW + 1;

  logic [W-1:0]  mem [NUM];
  logic [PW-1:0] ptr;
  logic [IW-1:0] idx;
  logic          live;

  assign idx  = ptr[IW-1:0];
  assign live = mode && (ptr < PW'(NUM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      rdata <= '0;
      for (int i = 0; i < NUM; i++) mem[i] <= '0;
    end else if (!mode) begin
      ptr <= '0;
    end else if (live && (wr || rd)) begin
      ptr <= ptr + 1'b1;
      if (wr) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_flat
    assign table_flat[g*W +: W] = mem[g];
  end
endmodule

// File: rtl/lbl_match.sv
module lbl_match #(
  parameter int NUM = 16,
  parameter int W   = 8
) (
  input  logic [NUM*W-1:0] table_flat,
  input  logic [W-1:0]     label,
  output logic             hit
);
  logic [NUM-1:0] eq;

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign eq[g] = (table_flat[g*W +: W] == label);
  end

  assign hit = |eq;
endmodule

// File: rtl/word_gate.sv
module word_gate #(
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          suspend,
  input  logic          pass,
  input  logic          in_valid,
  input  logic [WW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [WW-1:0] out_data,
  input  logic          out_ready
);
  logic take;
  logic even_flag;

  assign in_ready  = !suspend && (!out_valid || out_ready);
  assign take      = in_valid && in_ready;
  assign even_flag = ~^in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= pass;
      if (pass) out_data <= {even_flag, in_data[WW-2:0]};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/arinc_rx_filter.sv
module arinc_rx_filter
  import arinc_flt_pkg::*;
#(
  parameter int NUM_LABELS = 16,
  parameter int LABEL_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_data,
  input  logic               out_ready,
  input  logic               lbl_en,
  input  logic               sdi_en,
  input  logic [SDI_W-1:0]   sdi_code,
  input  logic               label_mode,
  input  logic               host_wr,
  input  logic [LABEL_W-1:0] host_wdata,
  input  logic               host_rd,
  output logic [LABEL_W-1:0] host_rdata
);
  filt_cfg_t                    cfg;
  logic [NUM_LABELS*LABEL_W-1:0] table_flat;
  logic                         hit;
  logic                         sdi_ok;
  logic                         pass;

  assign cfg = '{lbl_en: lbl_en, sdi_en: sdi_en, sdi_code: sdi_code};

  lbl_store #(.NUM(NUM_LABELS), .W(LABEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .mode(label_mode),
    .wr(host_wr), .wdata(host_wdata), .rd(host_rd),
    .rdata(host_rdata), .table_flat(table_flat)
  );

  lbl_match #(.NUM(NUM_LABELS), .W(LABEL_W)) u_match (
    .table_flat(table_flat), .label(in_data[LABEL_W-1:0]), .hit(hit)
  );

  always_comb begin
    sdi_ok = (in_data[SDI_LSB +: SDI_W] == cfg.sdi_code);
    pass   = (!cfg.lbl_en || hit) && (!cfg.sdi_en || sdi_ok);
  end

  word_gate #(.WW(WORD_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .suspend(label_mode), .pass(pass),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );
endmodule

// File: rtl/arinc_rx_filter_chk.sv
module arinc_rx_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        in_ready,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        out_ready,
  input logic        lbl_en,
  input logic        sdi_en,
  input logic [1:0]  sdi_code,
  input logic        label_mode
);
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_suspend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    label_mode |-> !in_ready);

  p_open_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !lbl_en && !sdi_en) |=>
      (out_valid && out_data[30:0] == $past(in_data[30:0])));

  p_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !lbl_en && !sdi_en) |=>
      (out_data[31] == ~^$past(in_data)));

  p_sdi_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && sdi_en && in_data[9:8] != sdi_code) |=> !out_valid);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind arinc_rx_filter arinc_rx_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .lbl_en(lbl_en), .sdi_en(sdi_en),
  .sdi_code(sdi_code), .label_mode(label_mode)
);

// File: tb/tb_arinc_rx_filter.sv
module tb_arinc_rx_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;
  logic        lbl_en = 1'b0;
  logic        sdi_en = 1'b0;
  logic [1:0]  sdi_code = 2'b00;
  logic        label_mode = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  arinc_rx_filter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .lbl_en(lbl_en), .sdi_en(sdi_en),
    .sdi_code(sdi_code), .label_mode(label_mode), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata)
  );

  function automatic logic [31:0] expect_word(logic [31:0] d);
    return {($countones(d) % 2 == 0), d[30:0]};
  endfunction

  function automatic logic [7:0] lbl_val(int i);
    return 8'(i * 17);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] d, bit exp_pass, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == exp_pass, tag, 32'(out_valid), 32'(exp_pass));
    if (exp_pass && out_valid)
      check(out_data == expect_word(d), tag, out_data, expect_word(d));
  endtask

  task automatic hwrite(logic [7:0] v);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(logic [7:0] exp, string tag);
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    check(host_rdata == exp, tag, 32'(host_rdata), 32'(exp));
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    label_mode = m;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    check(host_rdata == 8'h00, "R1 host_rdata", 32'(host_rdata), 0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_open();
    lbl_en = 0; sdi_en = 0;
    send(32'h1234_5678, 1'b1, "R2 open word a");
    send(32'hFFFF_FFFF, 1'b1, "R2 open word b");
    send(32'h0000_0001, 1'b1, "R3 odd count flag 0");
    send(32'h0000_0003, 1'b1, "R3 even count flag 1");
    send(32'h8000_0000, 1'b1, "R3 top bit counted");
  endtask

  task automatic t_load();
    set_mode(1'b1);
    for (int i = 0; i < 16; i++) hwrite(lbl_val(i));
    set_mode(1'b0);
  endtask

  task automatic t_readback();
    lbl_en = 0;
    set_mode(1'b1);
    for (int i = 0; i < 16; i++) hread(lbl_val(i), "R9 R8 readback order");
    set_mode(1'b0);
  endtask

  task automatic t_label();
    lbl_en = 1; sdi_en = 0;
    send(32'h0000_0322, 1'b1, "R4 label hit 0x22");
    send(32'h0000_0023, 1'b0, "R4 label miss 0x23");
    send(32'h0000_00FF, 1'b1, "R4 label hit last location");
    send(32'hABCD_0000, 1'b1, "R5 label 0x00 hit");
    lbl_en = 0;
  endtask

  task automatic t_sdi();
    lbl_en = 0; sdi_en = 1; sdi_code = 2'b10;
    send(32'h0000_0223, 1'b1, "R6 sdi match");
    send(32'h0000_0123, 1'b0, "R6 sdi mismatch");
    sdi_en = 0;
  endtask

  task automatic t_and();
    lbl_en = 1; sdi_en = 1; sdi_code = 2'b01;
    send(32'h0000_0144, 1'b1, "R7 both pass");
    send(32'h0000_0244, 1'b0, "R7 label ok sdi bad");
    send(32'h0000_0145, 1'b0, "R7 sdi ok label bad");
    send(32'h0000_0345, 1'b0, "R7 both bad");
    lbl_en = 0; sdi_en = 0;
  endtask

  task automatic t_suspend();
    set_mode(1'b1);
    @(negedge clk);
    check(in_ready == 1'b0, "R10 in_ready in label mode", 32'(in_ready), 0);
    in_valid = 1'b1;
    in_data = 32'h5555_0000;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R10 no word taken", 32'(out_valid), 0);
    set_mode(1'b0);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 nothing after exit", 32'(out_valid), 0);
  endtask

  task automatic t_overrun();
    set_mode(1'b1);
    for (int i = 0; i < 16; i++) hread(lbl_val(i), "R9 second session");
    hwrite(8'hEE);
    hread(lbl_val(15), "R12 read past end holds rdata");
    set_mode(1'b0);
    set_mode(1'b1);
    hread(lbl_val(0), "R11 R12 restart at 0 and table kept");
    hread(lbl_val(1), "R11 second location after restart");
    set_mode(1'b0);
  endtask

  task automatic t_backpressure();
    logic [31:0] a = 32'h0F0F_1234;
    logic [31:0] b = 32'h7000_0007;
    lbl_en = 0; sdi_en = 0;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = a;
    @(negedge clk);
    in_data = b;
    check(out_valid == 1'b1, "R13 word a registered", 32'(out_valid), 1);
    check(in_ready == 1'b0, "R13 stalled in_ready", 32'(in_ready), 0);
    @(negedge clk);
    @(negedge clk);
    check(out_data == expect_word(a), "R13 data held", out_data, expect_word(a));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R13 b taken on drain", 32'(out_valid), 1);
    check(out_data == expect_word(b), "R13 b data", out_data, expect_word(b));
    @(negedge clk);
    check(out_valid == 1'b0, "R13 drained", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open();
    t_load();
    t_readback();
    t_label();
    t_sdi();
    t_and();
    t_suspend();
    t_overrun();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule